// File: doc/BRIEF.md
# Write-back three-state snooping cache coherence controller

This block keeps one small direct-mapped, write-back cache coherent with its peers on a shared, atomic broadcast bus. Each line is Invalid, Shared (clean and readable, possibly held by other caches as well) or Exclusive (the only copy, writable and dirty). Processor reads and writes that hit complete without bus traffic. A miss becomes a read-miss or write-miss bus transaction. A write to a clean line is also handled as a write miss. When the line being replaced is dirty, its contents go out as a write-back before the new miss is placed.

The block also watches every transaction that other caches put on the bus. A snooped write miss to a line held Shared invalidates it. When the block owns a dirty copy that another cache asks for, it drives that copy on the bus in the same cycle and raises an abort that tells memory to drop its own response. Memory takes the supplied word as a write-back. A snoop always takes the bus cycle ahead of the local processor. A pending processor request looks at the updated line state again in the next cycle.

Each bus transaction is one cycle long. An external arbiter grants it, and the requester's fill data arrives alongside the grant. The bus command is a 2-bit code, with one address and one data word.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and with no request and no snoop, `cpu_done`, `bus_req` and `snp_abort` are all 0.
- R2: A processor read to a line that is Invalid or holds another tag raises `bus_req` with `bus_cmd` = 2'b01 (read miss) and the requested address. The granted cycle installs the fill word in Shared, so the read then completes as a hit returning that word.
- R3: A processor write to a line that is Invalid or Shared raises a write miss (`bus_cmd` = 2'b10). The granted cycle installs the line Exclusive, and the write then completes as a hit without bus traffic. A write to an Exclusive line with a matching tag completes in the cycle it is presented, with no bus request.
- R4: A read whose tag matches a Shared or Exclusive line asserts `cpu_done` in the same cycle with the stored word on `cpu_rdata`, and `bus_req` stays 0.
- R5: A miss whose line is Exclusive with another tag first requests a write-back (`bus_cmd` = 2'b11) carrying the victim address {stored tag, index} and the stored word. After that is granted, it requests the new miss.
- R6: A miss whose line is Shared with another tag places only the new miss, with no write-back.
- R7: A snooped write miss (`snp_cmd` = 2'b10) to a line held Shared with a matching tag invalidates it without raising `snp_abort`.
- R8: A snooped read miss (`snp_cmd` = 2'b01) to a line held Exclusive with a matching tag raises `snp_abort` in that cycle with the stored word on `snp_data`, and leaves the line Shared.
- R9: A snooped write miss to a line held Exclusive with a matching tag raises `snp_abort` with the stored word on `snp_data`, and leaves the line Invalid.
- R10: In any cycle where `snp_cmd` is not idle, `cpu_done` and `bus_req` are 0. A pending processor request is then decided again from the line state the snoop left behind.
- R11: Snooped transactions whose tag does not match the resident line, and snooped write-backs (`snp_cmd` = 2'b11), change no line and raise no abort.
- R12: Two addresses A1 and A2 share one line, and all caches start Invalid. This cache writes 10 to A1 and reads A1. A peer then reads A1, writes 20 to A1 and writes 40 to A2. At the end, memory holds 20 for A1 and the peer supplies 40 for A2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address; low bits pick the line |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_done | output | 1 | Request completes at the coming clock edge |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Grant; the transaction takes place at the coming edge |
| bus_cmd | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Address of the outgoing transaction |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill word, valid with the grant of a miss |
| snp_cmd | input | 2 | Command another cache is placing on the bus |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_abort | output | 1 | Dirty copy supplied; memory must not respond |
| snp_data | output | DATA_W | Supplied dirty word, valid with `snp_abort` |

## Verification
The hardest case is a snoop that arrives while this cache's own miss is still waiting for the bus, and that changes what the miss has to do. One example is a pending replacement of a dirty line whose owner loses it to a snooped read miss, so the write-back the request was about to issue is no longer needed. The bench holds back the grant for a set number of requesting cycles and injects the snoop at a chosen cycle of the pending request. Its reference model then predicts the command the controller must issue once it decides again. A second hard case is the two-cache ordering sequence. The peer cache is modelled in the bench, with its own write-back and with intervention on the fill path.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    L_INV = 2'b00,
    L_SHR = 2'b01,
    L_EXC = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WRBACK = 2'b11
  } bus_cmd_e;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store #(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  // processor-side read port
  input  logic [IDX_W-1:0]    a_idx,
  output msi_pkg::line_st_e   a_st,
  output logic [TAG_W-1:0]    a_tag,
  output logic [DATA_W-1:0]   a_dat,
  // snoop-side read port
  input  logic [IDX_W-1:0]    b_idx,
  output msi_pkg::line_st_e   b_st,
  output logic [TAG_W-1:0]    b_tag,
  output logic [DATA_W-1:0]   b_dat,
  // snoop state update (wins over processor update)
  input  logic                sw_en,
  input  logic [IDX_W-1:0]    sw_idx,
  input  msi_pkg::line_st_e   sw_st,
  // processor-side update
  input  logic                cw_en,
  input  logic [IDX_W-1:0]    cw_idx,
  input  msi_pkg::line_st_e   cw_st,
  input  logic                cw_tag_en,
  input  logic [TAG_W-1:0]    cw_tag,
  input  logic                cw_dat_en,
  input  logic [DATA_W-1:0]   cw_dat
);
  import msi_pkg::*;

  line_st_e            st_v  [LINES];
  logic [TAG_W-1:0]    tag_v [LINES];
  logic [DATA_W-1:0]   dat_v [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    logic              sel_s, sel_c;

    assign sel_s = sw_en && (sw_idx == IDX_W'(g));
    assign sel_c = cw_en && (cw_idx == IDX_W'(g));

    always_comb begin
      st_d = st_q;
      if (sel_s)      st_d = sw_st;
      else if (sel_c) st_d = cw_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= L_INV;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (sel_c && !sel_s && cw_tag_en) tag_q <= cw_tag;
    end

    always_ff @(posedge clk) begin
      if (sel_c && !sel_s && cw_dat_en) dat_q <= cw_dat;
    end

    assign st_v[g]  = st_q;
    assign tag_v[g] = tag_q;
    assign dat_v[g] = dat_q;
  end

  assign a_st  = st_v[a_idx];
  assign a_tag = tag_v[a_idx];
  assign a_dat = dat_v[a_idx];
  assign b_st  = st_v[b_idx];
  assign b_tag = tag_v[b_idx];
  assign b_dat = dat_v[b_idx];

endmodule

// File: rtl/msi_cpu_side.sv
module msi_cpu_side #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                snoop_busy,
  input  logic                bus_gnt,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  msi_pkg::line_st_e   ln_st,
  input  logic [TAG_W-1:0]    ln_tag,
  input  logic [DATA_W-1:0]   ln_dat,
  output logic [IDX_W-1:0]    idx,
  output logic                cpu_done,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                bus_req,
  output msi_pkg::bus_cmd_e   bus_cmd,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic                cw_en,
  output msi_pkg::line_st_e   cw_st,
  output logic                cw_tag_en,
  output logic [TAG_W-1:0]    cw_tag,
  output logic                cw_dat_en,
  output logic [DATA_W-1:0]   cw_dat
);
  import msi_pkg::*;

  logic [TAG_W-1:0] req_tag;
  logic             tag_match, hit, active, need_wb, granted;

  assign idx     = cpu_addr[IDX_W-1:0];
  assign req_tag = cpu_addr[ADDR_W-1:IDX_W];

  assign tag_match = (ln_st != L_INV) && (ln_tag == req_tag);
  assign hit       = tag_match && (!cpu_we || (ln_st == L_EXC));
  assign active    = cpu_req && !snoop_busy;
  assign need_wb   = (ln_st == L_EXC) && !tag_match;

  assign cpu_done  = active && hit;
  assign cpu_rdata = (cpu_done && !cpu_we) ? ln_dat : '0;
  assign bus_req   = active && !hit;
  assign granted   = bus_req && bus_gnt;

  always_comb begin
    bus_cmd   = BC_IDLE;
    bus_addr  = '0;
    bus_wdata = '0;
    if (bus_req) begin
      if (need_wb) begin
        bus_cmd   = BC_WRBACK;
        bus_addr  = {ln_tag, idx};
        bus_wdata = ln_dat;
      end else begin
        bus_cmd  = cpu_we ? BC_WRMISS : BC_RDMISS;
        bus_addr = cpu_addr;
      end
    end
  end

  always_comb begin
    cw_en     = 1'b0;
    cw_st     = ln_st;
    cw_tag_en = 1'b0;
    cw_tag    = req_tag;
    cw_dat_en = 1'b0;
    cw_dat    = bus_rdata;
    if (cpu_done && cpu_we) begin
      cw_en     = 1'b1;
      cw_st     = L_EXC;
      cw_dat_en = 1'b1;
      cw_dat    = cpu_wdata;
    end else if (granted) begin
      cw_en = 1'b1;
      case (bus_cmd)
        BC_WRBACK: cw_st = L_INV;
        BC_WRMISS: begin
          cw_st     = L_EXC;
          cw_tag_en = 1'b1;
          cw_dat_en = 1'b1;
        end
        default: begin
          cw_st     = L_SHR;
          cw_tag_en = 1'b1;
          cw_dat_en = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/msi_snoop_side.sv
module msi_snoop_side #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic [1:0]          snp_cmd,
  input  logic [ADDR_W-1:0]   snp_addr,
  input  msi_pkg::line_st_e   ln_st,
  input  logic [TAG_W-1:0]    ln_tag,
  input  logic [DATA_W-1:0]   ln_dat,
  output logic [IDX_W-1:0]    idx,
  output logic                snoop_busy,
  output logic                snp_abort,
  output logic [DATA_W-1:0]   snp_data,
  output logic                sw_en,
  output msi_pkg::line_st_e   sw_st
);
  import msi_pkg::*;

  bus_cmd_e cmd;
  logic     match;

  assign cmd        = bus_cmd_e'(snp_cmd);
  assign idx        = snp_addr[IDX_W-1:0];
  assign snoop_busy = (cmd != BC_IDLE);
  assign match      = (ln_st != L_INV) && (ln_tag == snp_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    snp_abort = 1'b0;
    snp_data  = '0;
    sw_en     = 1'b0;
    sw_st     = ln_st;
    if (match) begin
      case (cmd)
        BC_RDMISS: if (ln_st == L_EXC) begin
          snp_abort = 1'b1;
          snp_data  = ln_dat;
          sw_en     = 1'b1;
          sw_st     = L_SHR;
        end
        BC_WRMISS: begin
          snp_abort = (ln_st == L_EXC);
          snp_data  = (ln_st == L_EXC) ? ln_dat : '0;
          sw_en     = 1'b1;
          sw_st     = L_INV;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  import msi_pkg::*;

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  line_st_e          a_st, b_st, cw_st, sw_st;
  logic [TAG_W-1:0]  a_tag, b_tag, cw_tag;
  logic [DATA_W-1:0] a_dat, b_dat, cw_dat;
  logic              cw_en, cw_tag_en, cw_dat_en, sw_en, snoop_busy;
  bus_cmd_e          cmd_e;

  msi_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat),
    .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_dat(b_dat),
    .sw_en(sw_en), .sw_idx(b_idx), .sw_st(sw_st),
    .cw_en(cw_en), .cw_idx(a_idx), .cw_st(cw_st),
    .cw_tag_en(cw_tag_en), .cw_tag(cw_tag),
    .cw_dat_en(cw_dat_en), .cw_dat(cw_dat)
  );

  msi_snoop_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .ln_st(b_st), .ln_tag(b_tag), .ln_dat(b_dat),
    .idx(b_idx), .snoop_busy(snoop_busy),
    .snp_abort(snp_abort), .snp_data(snp_data),
    .sw_en(sw_en), .sw_st(sw_st)
  );

  msi_cpu_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cpu (
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .snoop_busy(snoop_busy), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .ln_st(a_st), .ln_tag(a_tag), .ln_dat(a_dat),
    .idx(a_idx), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(cmd_e), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cw_en(cw_en), .cw_st(cw_st), .cw_tag_en(cw_tag_en), .cw_tag(cw_tag),
    .cw_dat_en(cw_dat_en), .cw_dat(cw_dat)
  );

  assign bus_cmd = cmd_e;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_abort
);

  // R10: a foreign bus transaction stalls the processor side
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_cmd != 2'b00) |-> (!cpu_done && !bus_req));

  // R2: a raised request always carries a real command
  p_req_has_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_cmd != 2'b00));

  // R8: abort only answers a snooped miss
  p_abort_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> (snp_cmd == 2'b01 || snp_cmd == 2'b10));

  // R9: after surrendering on a write miss, the line no longer answers
  p_surrender_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_abort && snp_cmd == 2'b10) |=> !(snp_abort && snp_addr == $past(snp_addr)));

  // R5: a granted write-back is followed by the miss itself
  p_wb_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'b11) |=>
      (!cpu_req || snp_cmd != 2'b00 || (bus_req && bus_cmd != 2'b11)));

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_abort(snp_abort)
);

// File: tb/tb_msi_snoop_ctrl.sv
module tb_msi_snoop_ctrl;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LINES  = 4;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_req, cpu_we;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic              cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic              bus_req, bus_gnt;
  logic [1:0]        bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic [1:0]        snp_cmd;
  logic [ADDR_W-1:0] snp_addr;
  logic              snp_abort;
  logic [DATA_W-1:0] snp_data;

  // 250 MHz: 4-unit period
  always #2 clk = ~clk;

  msi_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut (.*);

  // reference model
  int m_st [LINES];   // 0 invalid, 1 shared, 2 exclusive
  int m_tag[LINES];
  int m_dat[LINES];
  int mem  [256];
  int peer_st, peer_addr, peer_dat;
  int hold_gnt;
  int n_chk, n_fail;
  bit last_done;
  int last_rdata;

  task automatic chk(bit ok, string tg, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tg, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // one clock: entered just after a falling edge with inputs set
  task automatic cycle();
    int si, stg, ci, ctg, e_cmd, e_addr, e_wd, fill;
    bit smatch, e_abort, busy, thit, hit, e_done, e_req, wb, g;
    string tg_s, tg_c;
    #1;
    si     = int'(snp_addr) % LINES;
    stg    = int'(snp_addr) >> IDX_W;
    smatch = (m_st[si] != 0) && (m_tag[si] == stg);
    e_abort = (snp_cmd == 2'b01 || snp_cmd == 2'b10) && smatch && (m_st[si] == 2);
    busy   = (snp_cmd != 2'b00);
    ci     = int'(cpu_addr) % LINES;
    ctg    = int'(cpu_addr) >> IDX_W;
    thit   = (m_st[ci] != 0) && (m_tag[ci] == ctg);
    hit    = thit && (!cpu_we || m_st[ci] == 2);
    e_done = cpu_req && !busy && hit;
    e_req  = cpu_req && !busy && !hit;
    wb     = (m_st[ci] == 2) && !thit;
    e_cmd  = !e_req ? 0 : wb ? 3 : (cpu_we ? 2 : 1);
    e_addr = wb ? ((m_tag[ci] << IDX_W) | ci) : int'(cpu_addr);
    e_wd   = wb ? m_dat[ci] : 0;

    if (!busy) tg_s = "R11";
    else if (smatch && m_st[si] == 2 && snp_cmd == 2'b01) tg_s = "R8";
    else if (smatch && m_st[si] == 2 && snp_cmd == 2'b10) tg_s = "R9";
    else if (smatch && snp_cmd == 2'b10) tg_s = "R7";
    else tg_s = "R11";
    if (busy) tg_c = "R10";
    else if (!cpu_req) tg_c = "R1";
    else if (hit) tg_c = cpu_we ? "R3" : "R4";
    else if (wb) tg_c = "R5";
    else if (m_st[ci] == 1 && !thit) tg_c = "R6";
    else tg_c = cpu_we ? "R3" : "R2";

    chk(cpu_done == e_done, tg_c, "cpu_done", int'(cpu_done), int'(e_done));
    chk(bus_req == e_req, tg_c, "bus_req", int'(bus_req), int'(e_req));
    chk(int'(bus_cmd) == e_cmd, tg_c, "bus_cmd", int'(bus_cmd), e_cmd);
    if (e_req) begin
      chk(int'(bus_addr) == e_addr, tg_c, "bus_addr", int'(bus_addr), e_addr);
      chk(int'(bus_wdata) == e_wd, tg_c, "bus_wdata", int'(bus_wdata), e_wd);
    end
    if (e_done && !cpu_we)
      chk(int'(cpu_rdata) == m_dat[ci], tg_c, "cpu_rdata", int'(cpu_rdata), m_dat[ci]);
    chk(snp_abort == e_abort, tg_s, "snp_abort", int'(snp_abort), int'(e_abort));
    if (e_abort)
      chk(int'(snp_data) == m_dat[si], tg_s, "snp_data", int'(snp_data), m_dat[si]);

    g = e_req && (hold_gnt == 0);
    if (e_req && hold_gnt > 0) hold_gnt--;
    fill = 0;
    if (g && e_cmd != 3) begin
      if (peer_st == 2 && peer_addr == e_addr) begin
        fill = peer_dat;
        mem[e_addr] = peer_dat;
        peer_st = (e_cmd == 1) ? 1 : 0;
      end else begin
        fill = mem[e_addr];
        if (e_cmd == 2 && peer_addr == e_addr) peer_st = 0;
      end
    end
    bus_gnt   = g;
    bus_rdata = DATA_W'(fill);
    last_done  = e_done;
    last_rdata = m_dat[ci];

    @(posedge clk);
    if (e_abort) mem[int'(snp_addr)] = m_dat[si];
    if (busy && smatch) begin
      if (snp_cmd == 2'b01 && m_st[si] == 2) m_st[si] = 1;
      else if (snp_cmd == 2'b10) m_st[si] = 0;
    end
    if (e_done && cpu_we) begin
      m_st[ci]  = 2;
      m_dat[ci] = int'(cpu_wdata);
    end else if (g) begin
      if (e_cmd == 3) begin
        mem[e_addr] = m_dat[ci];
        m_st[ci] = 0;
      end else begin
        m_st[ci]  = (e_cmd == 2) ? 2 : 1;
        m_tag[ci] = ctg;
        m_dat[ci] = fill;
      end
    end
    @(negedge clk);
    bus_gnt   = 1'b0;
    bus_rdata = '0;
  endtask

  task automatic cpu_op(bit we, int addr, int wd, output int rd,
                        input int snp_at = -1, input int scmd = 0, input int saddr = 0);
    bit ok = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = DATA_W'(wd);
    rd = 0;
    for (int k = 0; k < 40; k++) begin
      if (k == snp_at) begin snp_cmd = 2'(scmd); snp_addr = ADDR_W'(saddr); end
      cycle();
      snp_cmd = 2'b00; snp_addr = '0;
      if (last_done) begin ok = 1; rd = last_rdata; break; end
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
    chk(ok, we ? "R3" : "R2", "request completion", int'(ok), 1);
  endtask

  task automatic snoop(int cmd, int addr);
    snp_cmd = 2'(cmd); snp_addr = ADDR_W'(addr);
    cycle();
    snp_cmd = 2'b00; snp_addr = '0;
  endtask

  task automatic peer_rd(int a);
    if (peer_st != 0 && peer_addr == a) return;
    if (peer_st == 2) begin snoop(3, peer_addr); mem[peer_addr] = peer_dat; end
    snoop(1, a);
    peer_st = 1; peer_addr = a; peer_dat = mem[a];
  endtask

  task automatic peer_wr(int a, int v);
    if (!(peer_st == 2 && peer_addr == a)) begin
      if (peer_st == 2) begin snoop(3, peer_addr); mem[peer_addr] = peer_dat; end
      snoop(2, a);
    end
    peer_st = 2; peer_addr = a; peer_dat = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 0; bus_rdata = '0; snp_cmd = 2'b00; snp_addr = '0;
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    peer_st = 0; peer_addr = 0; peer_dat = 0; hold_gnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cycle(); // R1: quiet outputs after reset
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: got hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    int rd;
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < 256; i++) mem[i] = (i * 37 + 5) & 16'hFFFF;
    do_reset();

    // R2, R4: read miss then read hit
    cpu_op(0, 8'h10, 0, rd);
    chk(rd == mem[8'h10], "R2", "fill word", rd, mem[8'h10]);
    cpu_op(0, 8'h10, 0, rd);
    // R3: write to Shared line is a write miss, then plain write hit
    cpu_op(1, 8'h10, 16'h1234, rd);
    cpu_op(1, 8'h10, 16'h5678, rd);
    cpu_op(0, 8'h10, 0, rd);
    chk(rd == 16'h5678, "R3", "written word", rd, 16'h5678);
    // R5: dirty victim written back before read miss
    cpu_op(0, 8'h14, 0, rd);
    chk(mem[8'h10] == 16'h5678, "R5", "victim in memory", mem[8'h10], 16'h5678);
    // R6: Shared victim replaced silently
    cpu_op(0, 8'h18, 0, rd);
    // R7: snooped write miss invalidates Shared line
    snoop(2, 8'h18);
    cpu_op(0, 8'h18, 0, rd);
    // R8: snooped read miss to Exclusive line
    cpu_op(1, 8'h21, 16'h00AA, rd);
    snoop(1, 8'h21);
    chk(mem[8'h21] == 16'h00AA, "R8", "supplied word", mem[8'h21], 16'h00AA);
    cpu_op(1, 8'h21, 16'h00BB, rd);
    // R9: snooped write miss to Exclusive line
    snoop(2, 8'h21);
    snoop(1, 8'h21);
    cpu_op(0, 8'h21, 0, rd);
    chk(rd == 16'h00BB, "R9", "word after surrender", rd, 16'h00BB);
    // R11: mismatching tag and foreign write-back have no effect
    snoop(2, 8'h25);
    snoop(3, 8'h21);
    cpu_op(0, 8'h21, 0, rd);
    chk(rd == 16'h00BB, "R11", "line kept", rd, 16'h00BB);
    // R10: snoop in the same cycle as a would-be hit
    cpu_op(0, 8'h02, 0, rd);
    cpu_op(0, 8'h02, 0, rd, 0, 2, 8'h02);
    // R10: pending write-back cancelled by a snoop while grant is held
    cpu_op(1, 8'h03, 16'h0C0C, rd);
    hold_gnt = 2;
    cpu_op(0, 8'h07, 0, rd, 1, 1, 8'h03);
    chk(mem[8'h03] == 16'h0C0C, "R10", "supplied on snoop", mem[8'h03], 16'h0C0C);

    // R12: two-cache ordering sequence from an all-invalid start
    do_reset();
    mem[8'h40] = 0; mem[8'h44] = 0;
    cpu_op(1, 8'h40, 10, rd);
    cpu_op(0, 8'h40, 0, rd);
    chk(rd == 10, "R12", "own read", rd, 10);
    peer_rd(8'h40);
    chk(peer_dat == 10, "R12", "peer read", peer_dat, 10);
    peer_wr(8'h40, 20);
    peer_wr(8'h44, 40);
    chk(mem[8'h40] == 20, "R12", "memory A1", mem[8'h40], 20);
    cpu_op(0, 8'h40, 0, rd);
    chk(rd == 20, "R12", "read A1", rd, 20);
    cpu_op(0, 8'h44, 0, rd);
    chk(rd == 40, "R12", "read A2", rd, 40);

    repeat (3) cycle();
    summary();
    $finish;
  end

endmodule